// File: doc/BRIEF.md
# Regulator Undervoltage Fault Supervisor

This block watches four voltage regulators, each of which supplies a one-bit undervoltage flag from an analog comparator. The flags arrive with no timing relation to the block clock. Each flag is brought into the clock domain and then passed through a persistence filter, so that only a dip lasting a programmed number of consecutive cycles counts as a fault. Short dips are discarded.

When a fault is confirmed, a sticky status bit is set on the rising edge of the filtered fault. A per-regulator two-bit response setting then either does nothing more, turns off that one regulator, or requests a shutdown of the whole system. Status bits can be masked, and one interrupt output is the OR of the unmasked status bits. Reading the status register clears it. The regulator-off and system-shutdown outputs stay asserted until software clears them through a dedicated write.

Top module: `uv_fault_supervisor`

## Requirements
- R1: A regulator's fault is confirmed only when its synchronized flag has been high for at least the programmed number of consecutive clock samples. A pulse one sample shorter has no effect, and any low sample restarts the count.
- R2: The persistence threshold register sits at address 3 in bits [7:0] and resets to 16. A stored value of 0 acts as 1.
- R3: The response register at address 2 holds bits [2i+1:2i] for regulator i+1. The codes are: 00 takes no action, 01 sets `rail_off[i]`, and 10 or 11 sets `sys_shutdown`. All fields reset to 00.
- R4: A confirmed fault sets its status bit whatever its response code is.
- R5: A status bit is set only by a rising edge of the filtered fault. A fault held high does not set the bit again after a read has cleared it.
- R6: The status register at address 0 holds regulator 4, 3, 2 and 1 in bits 11, 10, 9 and 8. A read of address 0 returns the current bits and clears all of them.
- R7: If a rising edge and a clearing read fall in the same cycle, that regulator's status bit ends up set.
- R8: The mask register at address 1 uses the same bit positions as the status register. A mask bit of 1 stops its status bit from driving `uv_irq`, but that status bit is still set and readable.
- R9: `uv_irq` is high exactly when at least one status bit is set and unmasked.
- R10: `rail_off` and `sys_shutdown` stay high until a write to address 4. In that write, wdata[3:0] clears the matching `rail_off` bits and wdata[4] clears `sys_shutdown`. A new fault in the same cycle wins over the clear.
- R11: After reset, status, mask and responses are 0, all outputs are low, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_async | input | 4 | Raw undervoltage flags, bit i = regulator i+1 |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears the status bits |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| rail_off | output | 4 | Sticky request to turn off regulator i+1 |
| sys_shutdown | output | 1 | Sticky system shutdown request |
| uv_irq | output | 1 | OR of the unmasked status bits |

## Verification
Two events can fall in the same cycle. One is a confirmed fault edge setting a status bit. The other is a status read clearing all the bits. To provoke this, the bench raises a flag and counts the two synchronizer stages and the threshold samples, so that it can place a status read exactly on the clock edge where the filtered fault rises. That read must return the bit as still clear, and the next read must return it as set. A second pairing, a fault setting a sticky output while a clear write is issued, is guarded by an assertion that lets the set win.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'b00,
    ACT_RAIL    = 2'b01,
    ACT_SYS     = 2'b10,
    ACT_SYS_ALT = 2'b11
  } uv_act_e;

  localparam int ADR_STAT = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_ACT  = 2;
  localparam int ADR_THR  = 3;
  localparam int ADR_CLR  = 4;

  function automatic logic act_turns_off_rail(input logic [1:0] code);
    return code == ACT_RAIL;
  endfunction

  function automatic logic act_stops_system(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/uvs_persist.sv
module uvs_persist #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_async,
  input  logic [CNT_W-1:0] limit,
  output logic             fault,
  output logic             fault_rise
);

  logic             meta_q, sync_q, fault_d;
  logic [CNT_W-1:0] run_q;

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] t);
    return (t == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      run_q   <= '0;
      fault_d <= 1'b0;
    end else begin
      meta_q  <= flag_async;
      sync_q  <= meta_q;
      fault_d <= fault;
      if (!sync_q)
        run_q <= '0;
      else if (run_q < floor_one(limit))
        run_q <= run_q + 1'b1;
    end
  end

  assign fault      = (run_q >= floor_one(limit));
  assign fault_rise = fault & ~fault_d;

  assert_fault_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(sync_q));

endmodule

// File: rtl/uvs_response.sv
module uvs_response #(
  parameter int N_REG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REG-1:0]   fault_rise,
  input  logic [2*N_REG-1:0] act_codes,
  input  logic [N_REG-1:0]   clr_rail,
  input  logic               clr_sys,
  output logic [N_REG-1:0]   rail_off,
  output logic               sys_shutdown
);

  logic [N_REG-1:0] want_rail, want_sys;

  for (genvar i = 0; i < N_REG; i++) begin : g_dec
    assign want_rail[i] = fault_rise[i] & uvs_pkg::act_turns_off_rail(act_codes[2*i +: 2]);
    assign want_sys[i]  = fault_rise[i] & uvs_pkg::act_stops_system(act_codes[2*i +: 2]);

    assert_ignore_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_rise[i] && act_codes[2*i +: 2] == 2'b00 && !clr_rail[i]) |=> $stable(rail_off[i]));
    assert_rail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_off[i] && !clr_rail[i]) |=> rail_off[i]);
    assert_rail_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      want_rail[i] |=> rail_off[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_off     <= '0;
      sys_shutdown <= 1'b0;
    end else begin
      rail_off     <= (rail_off & ~clr_rail) | want_rail;
      sys_shutdown <= (sys_shutdown & ~clr_sys) | (|want_sys);
    end
  end

  assert_sys_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_shutdown && !clr_sys) |=> sys_shutdown);
  assert_sys_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|want_sys) |=> sys_shutdown);

endmodule

// File: rtl/uv_fault_supervisor.sv
module uv_fault_supervisor #(
  parameter int N_REG     = 4,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int STAT_LSB  = 8,
  parameter int THR_RESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REG-1:0]  uv_async,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_REG-1:0]  rail_off,
  output logic              sys_shutdown,
  output logic              uv_irq
);

  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(uvs_pkg::ADR_STAT);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(uvs_pkg::ADR_MASK);
  localparam logic [ADDR_W-1:0] AD_ACT  = ADDR_W'(uvs_pkg::ADR_ACT);
  localparam logic [ADDR_W-1:0] AD_THR  = ADDR_W'(uvs_pkg::ADR_THR);
  localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(uvs_pkg::ADR_CLR);
  localparam int              ACT_W   = 2 * N_REG;

  logic [N_REG-1:0] status_q, mask_q, fault, fault_rise, clr_rail;
  logic [ACT_W-1:0] act_q;
  logic [CNT_W-1:0] thr_q;
  logic             stat_read, clr_wr, clr_sys;
  logic             unused_wdata;

  for (genvar i = 0; i < N_REG; i++) begin : g_ch
    uvs_persist #(.CNT_W(CNT_W)) u_persist (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_async (uv_async[i]),
      .limit      (thr_q),
      .fault      (fault[i]),
      .fault_rise (fault_rise[i])
    );
  end

  uvs_response #(.N_REG(N_REG)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_rise   (fault_rise),
    .act_codes    (act_q),
    .clr_rail     (clr_rail),
    .clr_sys      (clr_sys),
    .rail_off     (rail_off),
    .sys_shutdown (sys_shutdown)
  );

  assign stat_read    = reg_rd && (reg_addr == AD_STAT);
  assign clr_wr       = reg_wr && (reg_addr == AD_CLR);
  assign clr_rail     = {N_REG{clr_wr}} & reg_wdata[N_REG-1:0];
  assign clr_sys      = clr_wr & reg_wdata[N_REG];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      act_q    <= '0;
      thr_q    <= CNT_W'(THR_RESET);
    end else begin
      status_q <= (status_q & ~{N_REG{stat_read}}) | fault_rise;
      if (reg_wr && reg_addr == AD_MASK) mask_q <= reg_wdata[STAT_LSB +: N_REG];
      if (reg_wr && reg_addr == AD_ACT)  act_q  <= reg_wdata[ACT_W-1:0];
      if (reg_wr && reg_addr == AD_THR)  thr_q  <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AD_STAT: reg_rdata[STAT_LSB +: N_REG] = status_q;
      AD_MASK: reg_rdata[STAT_LSB +: N_REG] = mask_q;
      AD_ACT:  reg_rdata[ACT_W-1:0]         = act_q;
      AD_THR:  reg_rdata[CNT_W-1:0]         = thr_q;
      default: reg_rdata = '0;
    endcase
  end

  assign uv_irq = |(status_q & ~mask_q);

  for (genvar i = 0; i < N_REG; i++) begin : g_chk
    assert_status_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_rise[i] |=> status_q[i]);
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && !fault_rise[i]) |=> !status_q[i]);
    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[i] && !fault_rise[i]) |=> !status_q[i]);
  end

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_irq |-> (status_q != '0));

endmodule

// File: tb/uv_fault_supervisor_test.sv
module uv_fault_supervisor_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  uv_async = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  rail_off;
  logic        sys_shutdown, uv_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  uv_fault_supervisor uut (
    .clk(clk), .rst_n(rst_n), .uv_async(uv_async), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rail_off(rail_off), .sys_shutdown(sys_shutdown), .uv_irq(uv_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk); uv_async[idx] = 1'b1;
    repeat (len) @(negedge clk);
    uv_async[idx] = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R11 rail_off", {12'h0, rail_off}, 16'h0);
    chk("R11 sys_shutdown", {15'h0, sys_shutdown}, 16'h0);
    chk("R11 irq", {15'h0, uv_irq}, 16'h0);
    rd(3'd0, d); chk("R11 status", d, 16'h0);
    rd(3'd1, d); chk("R11 mask", d, 16'h0);
    rd(3'd2, d); chk("R3 action reset", d, 16'h0);
    rd(3'd3, d); chk("R2 threshold reset", d, 16'd16);
    rd(3'd6, d); chk("R11 unmapped", d, 16'h0);
  endtask

  task automatic t_persist();
    logic [15:0] d;
    wr(3'd3, 16'd4);
    pulse(0, 3); settle();
    rd(3'd0, d); chk("R1 short pulse", d, 16'h0);
    pulse(0, 3); pulse(0, 3); settle();
    rd(3'd0, d); chk("R1 restart on gap", d, 16'h0);
    pulse(0, 4); settle();
    chk("R9 irq on fault", {15'h0, uv_irq}, 16'h1);
    rd(3'd0, d); chk("R1 exact threshold", d, 16'h0100);
    chk("R6 irq after read", {15'h0, uv_irq}, 16'h0);
    rd(3'd0, d); chk("R6 cleared by read", d, 16'h0);
  endtask

  task automatic t_thr_zero();
    logic [15:0] d;
    wr(3'd3, 16'd0);
    pulse(1, 1); settle();
    rd(3'd0, d); chk("R2 zero acts as one", d, 16'h0200);
    rd(3'd3, d); chk("R2 readback", d, 16'h0);
    wr(3'd3, 16'd4);
  endtask

  task automatic t_actions();
    logic [15:0] d;
    wr(3'd2, 16'h00E4);
    pulse(0, 6); settle();
    chk("R3 code00 no rail", {12'h0, rail_off}, 16'h0);
    chk("R3 code00 no sys", {15'h0, sys_shutdown}, 16'h0);
    rd(3'd0, d); chk("R4 status with code00", d, 16'h0100);
    pulse(1, 6); settle();
    chk("R3 code01 rail", {12'h0, rail_off}, 16'h0002);
    chk("R3 code01 no sys", {15'h0, sys_shutdown}, 16'h0);
    pulse(2, 6); settle();
    chk("R3 code10 sys", {15'h0, sys_shutdown}, 16'h1);
    rd(3'd0, d); chk("R4 status with actions", d, 16'h0600);
    wr(3'd4, 16'h0010);
    chk("R10 sys cleared", {15'h0, sys_shutdown}, 16'h0);
    chk("R10 rail kept", {12'h0, rail_off}, 16'h0002);
    pulse(3, 6); settle();
    chk("R3 code11 sys", {15'h0, sys_shutdown}, 16'h1);
    wr(3'd4, 16'h001F);
    chk("R10 all cleared rail", {12'h0, rail_off}, 16'h0);
    chk("R10 all cleared sys", {15'h0, sys_shutdown}, 16'h0);
    rd(3'd0, d); chk("R6 status reg4", d, 16'h0800);
    wr(3'd2, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd1, 16'h0100);
    rd(3'd1, d); chk("R8 mask readback", d, 16'h0100);
    pulse(0, 6); settle();
    chk("R8 masked no irq", {15'h0, uv_irq}, 16'h0);
    pulse(1, 6); settle();
    chk("R9 unmasked irq", {15'h0, uv_irq}, 16'h1);
    rd(3'd0, d); chk("R8 masked still set", d, 16'h0300);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] d;
    @(negedge clk); uv_async[2] = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd0, d); chk("R5 first edge", d, 16'h0400);
    repeat (10) @(negedge clk);
    rd(3'd0, d); chk("R5 level no reset", d, 16'h0);
    chk("R5 irq low while held", {15'h0, uv_irq}, 16'h0);
    uv_async[2] = 1'b0; settle();
    pulse(2, 6); settle();
    rd(3'd0, d); chk("R5 new edge", d, 16'h0400);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk); uv_async[0] = 1'b1;
    repeat (4 + 2) @(posedge clk);
    @(negedge clk); reg_addr = 3'd0; reg_rd = 1'b1;
    #1 d = reg_rdata;
    chk("R7 read before set", d, 16'h0);
    @(negedge clk); reg_rd = 1'b0;
    rd(3'd0, d); chk("R7 set survives read", d, 16'h0100);
    uv_async[0] = 1'b0; settle();
    rd(3'd0, d); chk("R7 then cleared", d, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_persist();
    t_thr_zero();
    t_actions();
    t_mask();
    t_level();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule